// File: doc/BRIEF.md
# Carry-Save Multi-Operand Adder Tree

This block adds a parameterised number of unsigned operands of equal width and returns their exact total. It contains no registers: it is combinational from operand bus to result. The operands come in on one packed bus. Operand `i` occupies bits `[i*OP_W +: OP_W]`, and operand 0 sits in the least significant slice.

Inside the block, layers of 3:2 compressors process the operands. Each layer takes groups of three vectors and turns each group into a sum vector and a carry vector. There is no carry movement between bit positions inside a layer. The carry vector is doubled by a one-place shift in the wiring. Vectors left over when a layer's count is not a multiple of three go straight through to the next layer. When only two vectors remain, a single ripple-carry adder merges them into the result.

Every vector inside the tree is zero-extended to the result width. That width always holds the largest possible total, so the result never wraps.

Top module: `csa_tree_sum`

## Requirements
- R1: `total_o` equals the unsigned sum of all `NUM_OPS` operands, where operand `i` is taken from `operands_i[i*OP_W +: OP_W]`.
- R2: `total_o` is `OP_W + $clog2(NUM_OPS)` bits wide. With every operand at its all-ones value, the output is `NUM_OPS*(2^OP_W-1)` with no wrap; with the defaults (6 operands of 4 bits) that is 90 on a 7-bit output.
- R3: The compressor cell gives a sum bit equal to the XOR of its three inputs and a carry bit equal to their majority, so that p+q+r = 2c+s. For p=9, q=12, r=13 it gives c=13 and s=8.
- R4: A carry vector goes to the next layer shifted up by one place, with no logic. The carry bit this shift drops is always zero, so no weight is lost.
- R5: Reduction runs layer by layer until two vectors remain. The final adder that merges them never produces a carry out of the result width.
- R6: When all operands are zero, the output is zero.
- R7: With the defaults, operands 13, 10, 5, 11, 12 and 1 give 52.
- R8: The output is purely combinational. It reflects a new operand set in the same clock cycle that the set is applied, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operands_i | input | NUM_OPS*OP_W | Packed unsigned operands, operand 0 in the low slice |
| total_o | output | OP_W+$clog2(NUM_OPS) | Full-width sum of all operands |

## Verification
Two pieces of work share the same evaluation: the compressor layers absorb carries in every column at once, and the final adder may then ripple a carry across its whole width. The all-ones pattern pushes the compressors to their largest carry vectors. Random operand sets and the small worked example reach final additions that ripple through many positions. Each outcome is judged against an integer sum of the operands that the bench computes on every clock. The compressor cell is also driven on its own, and its sum and carry are compared with the XOR and majority of its inputs.

// File: rtl/csa_tree_pkg.sv
package csa_tree_pkg;

  // Vectors remaining after a given number of 3:2 layers.
  function automatic int unsigned vec_count(int unsigned k, int unsigned lvl);
    int unsigned n;
    n = k;
    for (int unsigned i = 0; i < lvl; i++) begin
      n = 2 * (n / 3) + (n % 3);
    end
    return n;
  endfunction

  // Number of 3:2 layers needed to bring k vectors down to two.
  function automatic int unsigned level_count(int unsigned k);
    int unsigned n;
    int unsigned l;
    n = k;
    l = 0;
    while (n > 2) begin
      n = 2 * (n / 3) + (n % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/csa_row.sv
module csa_row #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] p_i,
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] r_i,
  output logic [WIDTH-1:0] s_o,
  output logic [WIDTH-1:0] c_o
);

  // Independent full adders, one per column, no carry chain.
  for (genvar b = 0; b < WIDTH; b++) begin : g_col
    assign s_o[b] = p_i[b] ^ q_i[b] ^ r_i[b];
    assign c_o[b] = (p_i[b] & q_i[b]) | (r_i[b] & (p_i[b] | q_i[b]));
  end

  // R3: weight of the three inputs is preserved as 2c + s
  always_comb begin
    if (!$isunknown({p_i, q_i, r_i})) begin
      a_r3_weight_kept: assert (({2'b00, p_i} + {2'b00, q_i} + {2'b00, r_i}) ==
                                ({1'b0, c_o, 1'b0} + {2'b00, s_o}));
    end
  end

endmodule

// File: rtl/cpa_final.sv
module cpa_final #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] sum_o
);

  logic [WIDTH:0] cy;

  assign cy[0] = 1'b0;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic half;
    assign half      = a_i[b] ^ b_i[b];
    assign sum_o[b]  = half ^ cy[b];
    assign cy[b+1]   = (a_i[b] & b_i[b]) | (cy[b] & half);
  end

  // R5: the merged total always fits the result width
  always_comb begin
    if (!$isunknown({a_i, b_i})) begin
      a_r5_no_carry_out: assert (cy[WIDTH] == 1'b0);
    end
  end

endmodule

// File: rtl/csa_tree_sum.sv
module csa_tree_sum
  import csa_tree_pkg::*;
#(
  parameter  int unsigned NUM_OPS = 6,
  parameter  int unsigned OP_W    = 4,
  localparam int unsigned SUM_W   = OP_W + $clog2(NUM_OPS)
) (
  input  logic [NUM_OPS*OP_W-1:0] operands_i,
  output logic [SUM_W-1:0]        total_o
);

  localparam int unsigned LEVELS = level_count(NUM_OPS);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned N = vec_count(NUM_OPS, l);
    logic [SUM_W-1:0] v [N];

    if (l == 0) begin : g_in
      for (genvar i = 0; i < N; i++) begin : g_op
        assign v[i] = SUM_W'(operands_i[i*OP_W +: OP_W]);
      end
    end else begin : g_red
      localparam int unsigned NP = vec_count(NUM_OPS, l - 1);
      localparam int unsigned G  = NP / 3;

      for (genvar g = 0; g < G; g++) begin : g_cell
        logic [SUM_W-1:0] s_w;
        logic [SUM_W-1:0] c_w;

        csa_row #(.WIDTH(SUM_W)) u_row (
          .p_i (g_lvl[l-1].v[3*g]),
          .q_i (g_lvl[l-1].v[3*g+1]),
          .r_i (g_lvl[l-1].v[3*g+2]),
          .s_o (s_w),
          .c_o (c_w)
        );

        assign v[2*g]   = s_w;
        assign v[2*g+1] = {c_w[SUM_W-2:0], 1'b0};

        // R4: the bit dropped by the doubling shift carries no weight
        always_comb begin
          if (!$isunknown(c_w)) begin
            a_r4_no_overflow: assert (c_w[SUM_W-1] == 1'b0);
          end
        end
      end

      for (genvar j = 0; j < NP - 3*G; j++) begin : g_pass
        assign v[2*G+j] = g_lvl[l-1].v[3*G+j];
      end
    end
  end

  cpa_final #(.WIDTH(SUM_W)) u_cpa (
    .a_i   (g_lvl[LEVELS].v[0]),
    .b_i   (g_lvl[LEVELS].v[1]),
    .sum_o (total_o)
  );

  // R6: zero operands give a zero total
  always_comb begin
    if (!$isunknown(operands_i) && operands_i == '0) begin
      a_r6_zero_in_zero_out: assert (total_o == '0);
    end
  end

endmodule

// File: tb/csa_tree_sum_test.sv
module csa_tree_sum_test;

  localparam int unsigned K  = 6;
  localparam int unsigned W  = 4;
  localparam int unsigned OW = W + $clog2(K);

  logic clk;
  logic rst_n;
  logic [K*W-1:0] ops;
  logic [OW-1:0]  total;

  logic [3:0] cp, cq, cr, cs, cc;

  int n_cmp;
  int n_bad;
  bit active;
  string tag;

  csa_tree_sum #(.NUM_OPS(K), .OP_W(W)) uut (
    .operands_i (ops),
    .total_o    (total)
  );

  csa_row #(.WIDTH(4)) uut_cell (
    .p_i (cp), .q_i (cq), .r_i (cr), .s_o (cs), .c_o (cc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int ref_sum(logic [K*W-1:0] v);
    int acc = 0;
    for (int i = 0; i < K; i++) acc += int'(v[i*W +: W]);
    return acc;
  endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Compare against the behavioural model on every clock while active
  always @(negedge clk) begin
    if (rst_n && active) check(tag, int'(total), ref_sum(ops));
  end

  task automatic apply(logic [K*W-1:0] v, string t);
    @(posedge clk);
    #1;
    ops = v;
    tag = t;
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; active = 1'b0; tag = "R1";
    rst_n = 1'b0;
    ops = '0;
    cp = 4'd0; cq = 4'd0; cr = 4'd0;
    repeat (3) @(posedge clk);
    #1;
    // R6: state under reset with zero operands
    check("R6 reset", int'(total), 0);
    rst_n = 1'b1;

    // R3: compressor cell worked example and an all-ones column set
    cp = 4'd9; cq = 4'd12; cr = 4'd13;
    #1;
    check("R3 carry", int'(cc), 13);
    check("R3 sum", int'(cs), 8);
    cp = 4'hF; cq = 4'h0; cr = 4'hF;
    #1;
    check("R3 maj", int'(cc), 15);
    check("R3 xor", int'(cs), 0);

    // R8: output follows a new operand set within the same cycle
    apply({4'd1, 4'd12, 4'd11, 4'd5, 4'd10, 4'd13}, "R8");
    #0.5;
    check("R8 same-cycle", int'(total), 52);

    active = 1'b1;
    // R7: worked six-operand example
    apply({4'd1, 4'd12, 4'd11, 4'd5, 4'd10, 4'd13}, "R7");
    @(negedge clk);
    check("R7 example", int'(total), 52);

    // R6: all zeros
    apply('0, "R6");
    @(negedge clk);
    check("R6 zeros", int'(total), 0);

    // R2: all ones, no wrap
    apply('1, "R2");
    @(negedge clk);
    check("R2 all-ones", int'(total), K * 15);

    // R4 / R5: patterns that stress carry vectors and long final ripple
    apply({4'd15, 4'd1, 4'd15, 4'd1, 4'd15, 4'd1}, "R4");
    @(negedge clk);
    apply({4'd0, 4'd0, 4'd0, 4'd0, 4'd1, 4'd15}, "R5");
    @(negedge clk);

    // R1: random operand sets
    for (int i = 0; i < 300; i++) begin
      apply(K*W'($urandom), "R1");
    end
    @(negedge clk);
    active = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #40000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule